// File: doc/BRIEF.md
# Divided-Clock Word Serializer

This block turns a parallel word of N bits into a continuous serial bit stream. It runs on a fast bit clock. It divides that clock by N to make a word clock, which it drives out so that the upstream logic can present words in the slow domain. Each word is captured on the rising edge of the word clock. It is then carried into the fast domain, loaded into a shift register and sent out one bit per fast cycle, most significant bit first.

The word clock is made from the bit clock, so the two clocks keep a fixed phase relation. The fast-domain alignment logic samples the word clock through two flops and spots its rising edge. It then issues a single-cycle load strobe. On the cycle the edge is spotted, a second parallel register copies the captured word into the fast domain. This gives the shift register a stable source on the load cycle. The first serial bit of each word always follows the word clock's rising edge by exactly two bit-clock cycles, and successive words follow one another with no idle bits.

Top module: `ser_word_tx`

## Requirements
- R1: `word_clk` has a period of N bit-clock cycles. In each period it is high for N - floor(N/2) cycles and low for floor(N/2) cycles.
- R2: The word present on `par_word` at a rising edge of `word_clk` appears on `ser_bit` most significant bit first, with bit N-1-k in the k-th bit cycle of the word.
- R3: The first (most significant) bit of a word is on `ser_bit` during the bit-clock cycle that begins on the second rising edge of `clk_bit` after the `word_clk` rising edge that captured it.
- R4: Words are sent back to back. The least significant bit of one word is directly followed by the most significant bit of the next, with no gap cycles.
- R5: Changes on `par_word` between rising edges of `word_clk` do not alter the word being serialized. Only the value present at the rising edge is sent.
- R6: While `rst_n` is low, `ser_bit` and `word_clk` are 0. After release, `ser_bit` stays 0 until the first word captured after reset reaches the output.
- R7: After `rst_n` is released, the first rising edge of `word_clk` occurs on the floor(N/2)-th rising edge of `clk_bit`.
- R8: Asserting `rst_n` low while a word is being sent clears `ser_bit` at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bit | input | 1 | Fast bit clock; one serial bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_clk | output | 1 | Bit clock divided by N; parallel words are taken on its rising edge |
| par_word | input | N | Parallel word, sampled on the rising edge of `word_clk` |
| ser_bit | output | 1 | Serial output, most significant bit first |

## Verification
The bench measures the exact cycle in which each word's first bit appears. A design that lost or added a register on the strobe path would shift every word by a cycle and fail the first-bit and last-bit checks. `par_word` is toggled with garbage during the cycles in which the fast domain copies the word. A design that fed the shift register from the raw input would then send the garbage. The bench also counts bit-clock edges from reset release to the first word-clock edge, and it pulls reset in the middle of a word. A divider that wakes at the wrong phase, or an output that only clears on a clock edge, shows up there.

// File: rtl/ser_pkg.sv
package ser_pkg;

    localparam int unsigned SER_MIN_N = 4;
    localparam int unsigned SER_MAX_N = 10;

    function automatic bit ser_n_ok(input int unsigned n);
        return (n >= SER_MIN_N) && (n <= SER_MAX_N);
    endfunction

endpackage

// File: rtl/ser_clkdiv.sv
module ser_clkdiv #(
    parameter int unsigned N = 8
) (
    input  logic clk_bit,
    input  logic rst_n,
    output logic word_clk
);
    localparam int unsigned CW = $clog2(N);
    localparam logic [CW-1:0] LAST_C = CW'(N - 1);
    localparam logic [CW-1:0] HALF_C = CW'(N / 2);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          div;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST_C) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        st_d.div = (st_d.cnt >= HALF_C);
    end

    always_ff @(posedge clk_bit or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_clk = st_q.div;

    // R1: the divided clock only rises when the count enters its upper half
    a_r1_rise_phase: assert property (@(posedge clk_bit) disable iff (!rst_n)
        $rose(st_q.div) |-> (st_q.cnt == HALF_C));

endmodule

// File: rtl/ser_edge_align.sv
module ser_edge_align #(
    parameter int unsigned N = 8
) (
    input  logic         clk_bit,
    input  logic         rst_n,
    input  logic         word_clk,
    input  logic [N-1:0] held_word,
    output logic         load,
    output logic [N-1:0] sync_word
);
    typedef struct packed {
        logic         smp1;
        logic         smp2;
        logic         load;
        logic [N-1:0] sync;
    } al_st_t;

    al_st_t st_d, st_q;
    logic   rise_seen;

    always_comb begin
        st_d      = st_q;
        rise_seen = st_q.smp1 & ~st_q.smp2;
        st_d.smp1 = word_clk;
        st_d.smp2 = st_q.smp1;
        st_d.load = rise_seen;
        if (rise_seen) begin
            st_d.sync = held_word;
        end
    end

    always_ff @(posedge clk_bit or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign load      = st_q.load;
    assign sync_word = st_q.sync;

    // R5: the fast-domain copy takes the slow-domain word on the detect cycle
    a_r5_sync_capture: assert property (@(posedge clk_bit) disable iff (!rst_n)
        rise_seen |=> (st_q.sync == $past(held_word)));

endmodule

// File: rtl/ser_shifter.sv
module ser_shifter #(
    parameter int unsigned N = 8
) (
    input  logic         clk_bit,
    input  logic         rst_n,
    input  logic         load,
    input  logic [N-1:0] sync_word,
    output logic         ser_bit
);
    typedef struct packed {
        logic [N-1:0] sreg;
    } sh_st_t;

    sh_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.sreg = {sync_word[N-2:0], 1'b0};
        end else begin
            st_d.sreg = {st_q.sreg[N-2:0], 1'b0};
        end
        ser_bit = load ? sync_word[N-1] : st_q.sreg[N-1];
    end

    always_ff @(posedge clk_bit or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2: after a load the second bit of the word is next in line
    a_r2_second_bit: assert property (@(posedge clk_bit) disable iff (!rst_n)
        $past(load) |-> (st_q.sreg[N-1] == $past(sync_word[N-2])));

endmodule

// File: rtl/ser_word_tx.sv
module ser_word_tx #(
    parameter int unsigned N = 8
) (
    input  logic         clk_bit,
    input  logic         rst_n,
    output logic         word_clk,
    input  logic [N-1:0] par_word,
    output logic         ser_bit
);
    import ser_pkg::*;

    if (!ser_n_ok(N)) begin : g_bad_width
        $error("ser_word_tx: N out of range");
    end

    logic [N-1:0] held_d, held_q;
    logic [N-1:0] sync_word;
    logic         load;

    ser_clkdiv #(.N(N)) i_div (
        .clk_bit  (clk_bit),
        .rst_n    (rst_n),
        .word_clk (word_clk)
    );

    always_comb begin
        held_d = par_word;
    end

    always_ff @(posedge word_clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= '0;
        end else begin
            held_q <= held_d;
        end
    end

    ser_edge_align #(.N(N)) i_align (
        .clk_bit   (clk_bit),
        .rst_n     (rst_n),
        .word_clk  (word_clk),
        .held_word (held_q),
        .load      (load),
        .sync_word (sync_word)
    );

    ser_shifter #(.N(N)) i_shift (
        .clk_bit   (clk_bit),
        .rst_n     (rst_n),
        .load      (load),
        .sync_word (sync_word),
        .ser_bit   (ser_bit)
    );

    // R3: the strobe follows the word clock rising edge by two bit cycles
    a_r3_load_lag: assert property (@(posedge clk_bit) disable iff (!rst_n)
        load |-> ($past(word_clk, 2) && !$past(word_clk, 3)));

    // R4: one strobe per word, never two in a row
    a_r4_single_strobe: assert property (@(posedge clk_bit) disable iff (!rst_n)
        load |=> !load);

endmodule

// File: tb/test_ser_word_tx.sv
module test_ser_word_tx;
    localparam int N = 8;
    localparam time CLK_PERIOD = 10;
    localparam int HALF = N / 2;
    localparam int NV = 12;
    localparam logic [N-1:0] VECS [NV] = '{
        8'hA5, 8'h3C, 8'hFF, 8'h00, 8'h80, 8'h01,
        8'h7E, 8'h55, 8'hAA, 8'hC3, 8'h0F, 8'hF0
    };

    logic         clk_bit = 1'b0;
    logic         rst_n   = 1'b0;
    logic         word_clk;
    logic [N-1:0] par_word = '1;
    logic         ser_bit;
    logic         mon_en  = 1'b0;
    logic         r5_mode = 1'b0;
    int           checks  = 0;
    int           fails   = 0;
    int           words   = 0;

    ser_word_tx #(.N(N)) i_ser_word_tx (
        .clk_bit  (clk_bit),
        .rst_n    (rst_n),
        .word_clk (word_clk),
        .par_word (par_word),
        .ser_bit  (ser_bit)
    );

    always #(CLK_PERIOD / 2) clk_bit = ~clk_bit;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_word(input logic [N-1:0] w, input bit r5);
        repeat (3) @(negedge clk_bit);
        for (int k = 0; k < N; k++) begin
            if (k > 0) @(negedge clk_bit);
            if (!rst_n) return;
            if (r5)
                chk(ser_bit == w[N-1-k], "R5 bit", int'(ser_bit), int'(w[N-1-k]));
            else if (k == 0)
                chk(ser_bit == w[N-1], "R3 first bit", int'(ser_bit), int'(w[N-1]));
            else if (k == N - 1)
                chk(ser_bit == w[0], "R4 last bit", int'(ser_bit), int'(w[0]));
            else
                chk(ser_bit == w[N-1-k], "R2 bit", int'(ser_bit), int'(w[N-1-k]));
        end
        words++;
    endtask

    initial begin
        forever begin
            @(posedge word_clk);
            if (mon_en && rst_n) begin
                fork
                    begin
                        automatic logic [N-1:0] cw = par_word;
                        automatic bit cr5 = r5_mode;
                        check_word(cw, cr5);
                    end
                join_none
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    task automatic release_and_check_start();
        @(negedge clk_bit);
        rst_n = 1'b1;
        mon_en = 1'b1;
        for (int j = 1; j <= HALF + 1; j++) begin
            @(negedge clk_bit);
            if (j <= HALF)
                chk(word_clk == (j >= HALF), "R7 first rise", int'(word_clk), int'(j >= HALF));
            chk(ser_bit == 1'b0, "R6 quiet after release", int'(ser_bit), 0);
        end
    endtask

    initial begin
        // R6: reset state with an all-ones input
        repeat (3) @(negedge clk_bit);
        chk(ser_bit == 1'b0, "R6 reset ser_bit", int'(ser_bit), 0);
        chk(word_clk == 1'b0, "R6 reset word_clk", int'(word_clk), 0);
        release_and_check_start();

        // R2 R3 R4: vector table streamed back to back
        for (int i = 0; i < NV; i++) begin
            @(posedge word_clk);
            @(negedge clk_bit);
            par_word = VECS[i];
        end
        @(posedge word_clk);

        // R1: shape of the divided clock over two periods
        @(negedge clk_bit);
        for (int j = 0; j < 2 * N; j++) begin
            chk(word_clk == ((j % N) < (N - HALF)), "R1 word_clk shape",
                int'(word_clk), int'((j % N) < (N - HALF)));
            @(negedge clk_bit);
        end

        // R5: garbage on the input while the fast domain copies the word
        r5_mode = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(posedge word_clk);
            @(negedge clk_bit);
            par_word = ~VECS[i];
            @(negedge clk_bit);
            par_word = VECS[i] ^ 8'h5A;
            @(negedge clk_bit);
            par_word = VECS[i + 4];
        end
        @(posedge word_clk);
        @(negedge clk_bit);
        r5_mode = 1'b0;
        par_word = 8'hFF;
        repeat (2 * N) @(negedge clk_bit);

        // R8: reset pulled in the middle of an all-ones word
        @(posedge word_clk);
        repeat (4) @(negedge clk_bit);
        chk(ser_bit == 1'b1, "R8 before reset", int'(ser_bit), 1);
        #(CLK_PERIOD / 4);
        rst_n = 1'b0;
        #1;
        chk(ser_bit == 1'b0, "R8 async clear", int'(ser_bit), 0);
        chk(word_clk == 1'b0, "R6 word_clk in reset", int'(word_clk), 0);
        repeat (3) @(negedge clk_bit);
        chk(ser_bit == 1'b0, "R6 held in reset", int'(ser_bit), 0);
        par_word = 8'h96;
        release_and_check_start();
        repeat (3 * N) @(negedge clk_bit);

        chk(words >= NV + 6, "R4 words completed", words, NV + 6);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule